// File: doc/BRIEF.md
# Mixed-Width Dual-Port Memory

This block is a synchronous memory with two independent ports that share one storage array but see it with different word shapes. Port A sees the array as many narrow words. Port B sees it as fewer wide words. Both views cover exactly the same bits, so a write through one port can be read back through the other once the write has been committed.

Each port has its own write enable, address, write data and registered read data, and both ports run on one clock. A cycle with the write enable high stores data and holds that port's read output. A cycle with the write enable low loads the read output from the addressed word.

Collisions have a defined result. Overlapping writes from both ports resolve in favour of port B, and a read on one port returns the old contents when the other port writes the same location in the same cycle. Memory contents are not reset. The read registers clear while reset is active, and writes are ignored until the synchronized reset has been released. The geometry is parameterized. Elaboration stops on any configuration whose two views differ in total size, or whose width ratio is not a power of two of at least two.

Top module: `mixwidth_dpram`

## Requirements
- R1: Port B word k holds port A word 2k in bits 7:0 and port A word 2k+1 in bits 15:8, with the default geometry of 8 bits by 256 words on port A and 16 bits by 128 words on port B.
- R2: A port A write with a_we_i high stores a_wdata_i at a_addr_i, and the value is read back from either port on any later read.
- R3: A port B write with b_we_i high stores all 16 bits of b_wdata_i at b_addr_i, and the value is read back from either port on any later read.
- R4: In a cycle where a port's write enable is high, that port's read output keeps its previous value.
- R5: In a cycle where a port's write enable is low, that port's read output shows the addressed word after the next rising clock edge, and it stays there until that port's next read.
- R6: When both ports write overlapping bits in the same cycle, port B's data is stored for those bits, and the other byte lanes are written normally.
- R7: A read on one port in the same cycle as a write by the other port to an overlapping location returns the contents from before the write.
- R8: While rst_ni is low, both read outputs are zero. Writes presented during reset, and during the two cycles of synchronized release after it, leave the memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Common clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| a_we_i | input | 1 | Port A write enable |
| a_addr_i | input | 8 | Port A narrow word address |
| a_wdata_i | input | 8 | Port A write data |
| a_rdata_o | output | 8 | Port A registered read data |
| b_we_i | input | 1 | Port B write enable |
| b_addr_i | input | 7 | Port B wide word address |
| b_wdata_i | input | 16 | Port B write data |
| b_rdata_o | output | 16 | Port B registered read data |

## Verification
The bench builds the block with the default geometry: 8-bit by 256-word on port A and 16-bit by 128-word on port B. At that size every narrow address and every wide address can be written and read back in full sweeps from each side, which checks the byte-lane mapping at every word. Directed same-cycle collisions then cover overlapping writes and cross-port read-before-write. A reset applied in the middle of traffic, with writes held active, shows that reset clears the outputs and leaves the contents alone. Long random mixed traffic, biased towards shared locations, is checked against a byte-array model every cycle.

// File: rtl/mdp_pkg.sv
package mdp_pkg;

  function automatic bit mdp_is_pow2(input int v);
    return (v > 0) && ((v & (v - 1)) == 0);
  endfunction

  function automatic bit mdp_geometry_ok(input int aw, input int ad,
                                         input int bw, input int bd);
    if (aw <= 0 || bw <= 0 || ad <= 0 || bd <= 0) return 1'b0;
    if (aw * ad != bw * bd) return 1'b0;
    if (bw % aw != 0) return 1'b0;
    if (bw / aw < 2) return 1'b0;
    return mdp_is_pow2(bw / aw) && mdp_is_pow2(bd);
  endfunction

endpackage

// File: rtl/mdp_rst_sync.sv
module mdp_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= 2'b00;
    else         stage_q <= stage_d;
  end

  assign rst_sync_no = stage_q[1];
endmodule

// File: rtl/mdp_lane_bank.sv
module mdp_lane_bank #(
  parameter int W    = 8,
  parameter int ROWS = 128,
  localparam int RW  = $clog2(ROWS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          a_we_i,
  input  logic [RW-1:0] a_row_i,
  input  logic [W-1:0]  a_data_i,
  input  logic          b_we_i,
  input  logic [RW-1:0] b_row_i,
  input  logic [W-1:0]  b_data_i,
  output logic [W-1:0]  a_rd_o,
  output logic [W-1:0]  b_rd_o
);
  logic [W-1:0] mem [ROWS];

  // Port B is applied last so it takes the row when both ports hit it.
  always_ff @(posedge clk_i) begin
    if (a_we_i) mem[a_row_i] <= a_data_i;
    if (b_we_i) mem[b_row_i] <= b_data_i;
  end

  // Combinational read of the pre-edge contents; the caller registers it.
  assign a_rd_o = mem[a_row_i];
  assign b_rd_o = mem[b_row_i];

  AST_A_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_we_i && !(b_we_i && (b_row_i == a_row_i))) |=> mem[$past(a_row_i)] == $past(a_data_i)); // R2
  AST_B_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_we_i |=> mem[$past(b_row_i)] == $past(b_data_i)); // R3
  AST_B_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_we_i && b_we_i && (a_row_i == b_row_i)) |=> mem[$past(a_row_i)] == $past(b_data_i)); // R6
endmodule

// File: rtl/mdp_rd_reg.sv
module mdp_rd_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q_o;
    if (load_i) q_d = d_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= q_d;
  end

  AST_HOLD_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(q_o)); // R4
endmodule

// File: rtl/mixwidth_dpram.sv
module mixwidth_dpram
  import mdp_pkg::*;
#(
  parameter int A_WIDTH = 8,
  parameter int A_DEPTH = 256,
  parameter int B_WIDTH = 16,
  parameter int B_DEPTH = 128,
  localparam int A_AW   = $clog2(A_DEPTH),
  localparam int B_AW   = $clog2(B_DEPTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               a_we_i,
  input  logic [A_AW-1:0]    a_addr_i,
  input  logic [A_WIDTH-1:0] a_wdata_i,
  output logic [A_WIDTH-1:0] a_rdata_o,
  input  logic               b_we_i,
  input  logic [B_AW-1:0]    b_addr_i,
  input  logic [B_WIDTH-1:0] b_wdata_i,
  output logic [B_WIDTH-1:0] b_rdata_o
);
  localparam int RATIO     = B_WIDTH / A_WIDTH;
  localparam int LANE_BITS = (RATIO > 1) ? $clog2(RATIO) : 1;

  generate
    if (!mdp_geometry_ok(A_WIDTH, A_DEPTH, B_WIDTH, B_DEPTH)) begin : g_bad_geometry
      $error("mixwidth_dpram: port views must cover equal bits with a power-of-two ratio of at least two");
    end
  endgenerate

  logic run;
  mdp_rst_sync u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (run)
  );

  logic [LANE_BITS-1:0]            a_lane;
  logic [B_AW-1:0]                 a_row;
  logic [RATIO-1:0]                a_hit;
  logic                            b_wr;
  logic [RATIO-1:0][A_WIDTH-1:0]   lane_rd_a;
  logic [RATIO-1:0][A_WIDTH-1:0]   lane_rd_b;
  logic [A_WIDTH-1:0]              a_rd_sel;
  logic [B_WIDTH-1:0]              b_rd_word;

  assign a_lane = a_addr_i[LANE_BITS-1:0];
  assign a_row  = a_addr_i[A_AW-1:LANE_BITS];
  assign b_wr   = b_we_i && run;

  // Narrow-address low bits pick the byte lane: lane l holds bits l*A_WIDTH upward.
  always_comb begin
    for (int l = 0; l < RATIO; l++) begin
      a_hit[l] = a_we_i && run && (a_lane == LANE_BITS'(l));
    end
  end

  generate
    for (genvar g = 0; g < RATIO; g++) begin : g_lane
      mdp_lane_bank #(
        .W    (A_WIDTH),
        .ROWS (B_DEPTH)
      ) u_bank (
        .clk_i    (clk_i),
        .rst_ni   (run),
        .a_we_i   (a_hit[g]),
        .a_row_i  (a_row),
        .a_data_i (a_wdata_i),
        .b_we_i   (b_wr),
        .b_row_i  (b_addr_i),
        .b_data_i (b_wdata_i[g*A_WIDTH +: A_WIDTH]),
        .a_rd_o   (lane_rd_a[g]),
        .b_rd_o   (lane_rd_b[g])
      );
    end
  endgenerate

  assign a_rd_sel  = lane_rd_a[a_lane];
  assign b_rd_word = lane_rd_b;

  mdp_rd_reg #(.W(A_WIDTH)) u_rd_a (
    .clk_i  (clk_i),
    .rst_ni (run),
    .load_i (!a_we_i),
    .d_i    (a_rd_sel),
    .q_o    (a_rdata_o)
  );

  mdp_rd_reg #(.W(B_WIDTH)) u_rd_b (
    .clk_i  (clk_i),
    .rst_ni (run),
    .load_i (!b_we_i),
    .d_i    (b_rd_word),
    .q_o    (b_rdata_o)
  );

  AST_A_READS_OLD: assert property (@(posedge clk_i) disable iff (!run)
    (!a_we_i && b_we_i && (a_row == b_addr_i)) |=> a_rdata_o == $past(a_rd_sel)); // R7
  AST_B_READS_OLD: assert property (@(posedge clk_i) disable iff (!run)
    (!b_we_i && a_we_i && (a_row == b_addr_i)) |=> b_rdata_o == $past(b_rd_word)); // R7
endmodule

// File: tb/mixwidth_dpram_tb_top.sv
`timescale 1ns/1ps
module mixwidth_dpram_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        a_we;
  logic [7:0]  a_addr;
  logic [7:0]  a_wdata;
  logic [7:0]  a_rdata;
  logic        b_we;
  logic [6:0]  b_addr;
  logic [15:0] b_wdata;
  logic [15:0] b_rdata;

  logic [7:0]  ref_mem [256];
  logic [7:0]  exp_a;
  logic [15:0] exp_b;
  int          n_checks = 0;
  int          n_fail   = 0;
  bit          done     = 1'b0;

  always #2.5 clk = ~clk;

  mixwidth_dpram dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .a_we_i    (a_we),
    .a_addr_i  (a_addr),
    .a_wdata_i (a_wdata),
    .a_rdata_o (a_rdata),
    .b_we_i    (b_we),
    .b_addr_i  (b_addr),
    .b_wdata_i (b_wdata),
    .b_rdata_o (b_rdata)
  );

  task automatic chk(input string req, input string what,
                     input logic [15:0] got, input logic [15:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // Model the edge from the inputs now applied, clock it, then compare both ports.
  task automatic step(input string req);
    if (!a_we) exp_a = ref_mem[a_addr];
    if (!b_we) exp_b = {ref_mem[{b_addr, 1'b1}], ref_mem[{b_addr, 1'b0}]};
    if (a_we) ref_mem[a_addr] = a_wdata;
    if (b_we) begin
      ref_mem[{b_addr, 1'b0}] = b_wdata[7:0];
      ref_mem[{b_addr, 1'b1}] = b_wdata[15:8];
    end
    @(posedge clk);
    #1;
    chk(req, "port A", {8'h00, a_rdata}, {8'h00, exp_a});
    chk(req, "port B", b_rdata, exp_b);
  endtask

  task automatic idle();
    a_we = 1'b0; b_we = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b1;
    a_we = 1'b0; a_addr = '0; a_wdata = '0;
    b_we = 1'b0; b_addr = '0; b_wdata = '0;
    exp_a = '0; exp_b = '0;
    #1 rst_n = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    chk("R8", "reset port A", {8'h00, a_rdata}, 16'h0000);
    chk("R8", "reset port B", b_rdata, 16'h0000);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;

    // R2 / R1: fill every narrow word via A, read every wide word via B.
    for (int i = 0; i < 256; i++) begin
      a_we = 1'b1; a_addr = 8'(i); a_wdata = 8'((i * 29 + 7) & 255);
      b_we = 1'b0; b_addr = 7'(i / 2);
      step("R4");
    end
    a_we = 1'b0;
    for (int k = 0; k < 128; k++) begin
      b_addr = 7'(k);
      step("R1");
      chk("R1", "B word arith", b_rdata,
          {8'(((2 * k + 1) * 29 + 7) & 255), 8'(((2 * k) * 29 + 7) & 255)});
    end
    for (int i = 0; i < 256; i++) begin
      a_addr = 8'(i);
      step("R2");
      chk("R2", "A byte arith", {8'h00, a_rdata}, {8'h00, 8'((i * 29 + 7) & 255)});
    end

    // R3 / R1: fill every wide word via B, read every narrow word via A.
    for (int k = 0; k < 128; k++) begin
      b_we = 1'b1; b_addr = 7'(k); b_wdata = 16'((k * 517 + 3001) & 16'hFFFF);
      a_we = 1'b0; a_addr = 8'(255 - k);
      step("R3");
    end
    b_we = 1'b0;
    for (int i = 0; i < 256; i++) begin
      a_addr = 8'(i);
      step("R1");
      chk("R3", "A byte of B word", {8'h00, a_rdata},
          {8'h00, (i % 2 == 1) ? 8'(((i / 2) * 517 + 3001) >> 8)
                               : 8'(((i / 2) * 517 + 3001) & 255)});
    end

    // R6: overlapping same-cycle writes on both lanes; B must win.
    for (int k = 0; k < 8; k++) begin
      a_we = 1'b1; a_addr = 8'(2 * k + (k % 2)); a_wdata = 8'hA5;
      b_we = 1'b1; b_addr = 7'(k); b_wdata = 16'(16'h1234 + k);
      step("R6");
      idle();
      a_addr = 8'(2 * k + (k % 2));
      b_addr = 7'(k);
      step("R6");
      chk("R6", "B data kept", b_rdata, 16'(16'h1234 + k));
    end

    // R7: cross-port read of a location written by the other port in the same cycle.
    for (int k = 8; k < 16; k++) begin
      a_we = 1'b1; a_addr = 8'(2 * k + 1); a_wdata = 8'h3C;
      b_we = 1'b0; b_addr = 7'(k);
      step("R7");
      a_we = 1'b0; a_addr = 8'(2 * k);
      b_we = 1'b1; b_addr = 7'(k); b_wdata = 16'hBEEF;
      step("R7");
      idle();
      step("R5");
    end

    // R5: random mixed traffic, biased toward shared locations.
    for (int n = 0; n < 3000; n++) begin
      a_we    = ($urandom % 3) == 0;
      b_we    = ($urandom % 3) == 0;
      a_addr  = 8'($urandom);
      a_wdata = 8'($urandom);
      b_wdata = 16'($urandom);
      b_addr  = (($urandom % 2) == 0) ? a_addr[7:1] : 7'($urandom);
      step("R5");
    end

    // R8: reset in the middle of traffic with writes held active.
    idle();
    a_addr = 8'd10; b_addr = 7'd40;
    step("R5");
    rst_n = 1'b0;
    a_we = 1'b1; a_wdata = 8'hEE;
    b_we = 1'b1; b_wdata = 16'hDDDD;
    #1;
    chk("R8", "async clear A", {8'h00, a_rdata}, 16'h0000);
    chk("R8", "async clear B", b_rdata, 16'h0000);
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    idle();
    exp_a = '0; exp_b = '0;
    @(posedge clk);
    #1;
    step("R8");
    step("R8");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule